// File: doc/BRIEF.md
# Parallel Bus Master

This block lets a host run single read and write cycles against an external device that sits on a plain parallel bus. The host sees four registers: control, address, data and pin mask. The external side has an address bus, one chip select, separate read and write strobes, and split data-in and data-out buses. Each bus cycle has the same shape. Chip select and the address come up for one setup clock. The strobe is then held for a programmed count of 1 to 16 clocks. A final hold clock keeps chip select high with the strobe released.

Reads are prefetched. When the host reads the data register it receives the value the register already holds, and that same read starts a new external read. The sampled bus value is stored in the data register and is returned by the following host read. So the first read after enabling is a dummy. A read issued while a cycle is still running is dropped and returns the same stale value again.

A write to the data register launches an external write to the programmed address. Two optional behaviours exist: the address can step by one after every completed cycle, and a one-clock interrupt pulse can mark the end of each cycle.

Top module: `pmb_master`

## Requirements
- R1: While the enable bit (control bit 15) is 0 there is no bus activity. Busy, overflow, address and data all read 0. Host writes to the address (offset 1) and data (offset 2) registers are ignored.
- R2: Control offset 0 holds these fields: strobe length minus one in bits 3:0, auto-increment in bit 4, interrupt enable in bit 5, word mode in bit 6, busy (read only) in bit 8, overflow (read only) in bit 9, enable in bit 15. The mask register is offset 3. Fields 3:0 to 6 and the mask change only while the block is disabled. After reset the control register reads 0 and the mask reads all ones.
- R3: A host read of the data register returns the current register value and, when the block is idle, starts an external read. The first read after enabling returns 0.
- R4: In a read cycle, chip select and the address come up one clock before the read strobe. The strobe stays high for exactly (length field + 1) clocks. Chip select stays high one clock after the strobe. The bus input sampled in the last strobe clock is stored in the data register.
- R5: A host write to the data register stores the value and launches a write cycle with the same timing as R4, using the write strobe. The stored value is driven on the data-out bus.
- R6: Busy is high from the clock after a cycle is launched through its hold clock.
- R7: A data-register access or address write that arrives while busy is ignored and sets the sticky overflow bit. Only disabling the block clears overflow.
- R8: Address pins whose mask bit is 0 are driven low. The other pins carry the address register.
- R9: The interrupt output pulses for exactly one clock, in the hold clock of each cycle. It pulses only when the interrupt enable bit is 1.
- R10: With auto-increment set, the address register increments by one after each completed cycle.
- R11: With word mode 0, only data bits 7:0 are driven and captured. The upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one clock per access |
| host_wr | input | 1 | 1 for a write access, 0 for a read access |
| host_reg | input | 2 | Register offset |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data for the selected register |
| bus_addr | output | AW | Masked external address |
| bus_cs | output | 1 | Chip select, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_dout | output | DW | External write data |
| bus_din | input | DW | External read data |
| irq | output | 1 | End-of-cycle interrupt pulse |

## Verification
Some properties are checked on every clock: the read and write strobes never overlap, each strobe is framed by setup and hold clocks of chip select, the interrupt lasts a single clock inside the hold clock, overflow is sticky, and the configuration stays frozen while enabled. Other behaviours need directed bench scenarios. These are the prefetch ordering of returned data, the exact strobe length for each programmed count, pin masking, byte-mode truncation, the addresses produced by auto-increment, and whether accesses made while busy or disabled leave the registers and the bus unchanged.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  localparam int STB_W  = 4;
  localparam int BYTE_W = 8;

  localparam int B_EN   = 15;
  localparam int B_OVF  = 9;
  localparam int B_BUSY = 8;
  localparam int B_WORD = 6;
  localparam int B_IRQ  = 5;
  localparam int B_INC  = 4;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ADDR = 2'd1,
    REG_DATA = 2'd2,
    REG_MASK = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } bus_st_e;

  typedef struct packed {
    logic             word;
    logic             irq_en;
    logic             inc;
    logic [STB_W-1:0] len;
  } cfg_t;
endpackage

// File: rtl/pmb_regs.sv
module pmb_regs
  import pmb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [1:0]    host_reg,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          busy,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_data,
  input  logic          cyc_done,
  output logic          en,
  output cfg_t          cfg,
  output logic [AW-1:0] mask,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          start_rd,
  output logic          start_wr
);
  localparam logic [DW-1:0] LOW_MASK = DW'({BYTE_W{1'b1}});

  logic          en_q, en_d;
  cfg_t          cfg_q, cfg_d;
  logic [AW-1:0] mask_q, mask_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          ovf_q, ovf_d;

  logic          acc_data, addr_wr, ctrl_wr, mask_wr, ovf_set;
  logic [DW-1:0] width_mask;

  assign acc_data   = host_sel && (host_reg == REG_DATA);
  assign addr_wr    = host_sel && host_wr && (host_reg == REG_ADDR);
  assign ctrl_wr    = host_sel && host_wr && (host_reg == REG_CTRL);
  assign mask_wr    = host_sel && host_wr && (host_reg == REG_MASK);
  assign start_rd   = en_q && !busy && acc_data && !host_wr;
  assign start_wr   = en_q && !busy && acc_data && host_wr;
  assign ovf_set    = en_q && busy && (acc_data || addr_wr);
  assign width_mask = cfg_q.word ? {DW{1'b1}} : LOW_MASK;

  always_comb begin
    en_d   = en_q;
    cfg_d  = cfg_q;
    mask_d = mask_q;
    addr_d = addr_q;
    data_d = data_q;
    ovf_d  = ovf_q;
    if (ctrl_wr) begin
      en_d = host_wdata[B_EN];
      if (!en_q) begin
        cfg_d.word   = host_wdata[B_WORD];
        cfg_d.irq_en = host_wdata[B_IRQ];
        cfg_d.inc    = host_wdata[B_INC];
        cfg_d.len    = host_wdata[STB_W-1:0];
      end
    end
    if (mask_wr && !en_q) mask_d = AW'(host_wdata);
    if (!en_q) begin
      addr_d = '0;
      data_d = '0;
      ovf_d  = 1'b0;
    end else begin
      if (addr_wr && !busy)          addr_d = AW'(host_wdata);
      else if (cyc_done && cfg_q.inc) addr_d = addr_q + 1'b1;
      if (start_wr)    data_d = host_wdata & width_mask;
      else if (cap_en) data_d = cap_data & width_mask;
      if (ovf_set) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cfg_q  <= '0;
      mask_q <= '1;
      addr_q <= '0;
      data_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      cfg_q  <= cfg_d;
      mask_q <= mask_d;
      addr_q <= addr_d;
      data_q <= data_d;
      ovf_q  <= ovf_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_reg)
      REG_CTRL: begin
        host_rdata[B_EN]        = en_q;
        host_rdata[B_OVF]       = ovf_q;
        host_rdata[B_BUSY]      = busy;
        host_rdata[B_WORD]      = cfg_q.word;
        host_rdata[B_IRQ]       = cfg_q.irq_en;
        host_rdata[B_INC]       = cfg_q.inc;
        host_rdata[STB_W-1:0]   = cfg_q.len;
      end
      REG_ADDR: host_rdata = DW'(addr_q);
      REG_DATA: host_rdata = data_q;
      default:  host_rdata = DW'(mask_q);
    endcase
  end

  assign en   = en_q;
  assign cfg  = cfg_q;
  assign mask = mask_q;
  assign addr = addr_q;
  assign data = data_q;

  // R7: overflow stays set while enabled
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && en_q) |=> ovf_q)
    else $error("overflow flag dropped while enabled");

  // R2: configuration frozen while enabled
  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> ($stable(cfg_q) && $stable(mask_q)))
    else $error("configuration changed while enabled");

  // R1: nothing captured or stored while disabled
  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (data_q == '0 && addr_q == '0 && !ovf_q))
    else $error("runtime state not cleared while disabled");
endmodule

// File: rtl/pmb_seq.sv
module pmb_seq
  import pmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [STB_W-1:0] len,
  input  logic             start_rd,
  input  logic             start_wr,
  output logic             busy,
  output logic             bus_cs,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             cap_en,
  output logic             cyc_done
);
  bus_st_e          st_q, st_d;
  logic [STB_W-1:0] cnt_q, cnt_d;
  logic             is_rd_q, is_rd_d;
  logic             last_stb;

  assign last_stb = (st_q == ST_STROBE) && (cnt_q == len);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    is_rd_d = is_rd_q;
    case (st_q)
      ST_IDLE: if (start_rd || start_wr) begin
        st_d    = ST_SETUP;
        is_rd_d = start_rd;
      end
      ST_SETUP: begin
        st_d  = ST_STROBE;
        cnt_d = '0;
      end
      ST_STROBE: begin
        if (last_stb) st_d = ST_HOLD;
        else          cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (!en) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      is_rd_q <= is_rd_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign bus_cs   = busy;
  assign bus_rd   = (st_q == ST_STROBE) && is_rd_q;
  assign bus_wr   = (st_q == ST_STROBE) && !is_rd_q;
  assign cap_en   = last_stb && is_rd_q && en;
  assign cyc_done = (st_q == ST_HOLD);

  // R4: strobes are exclusive
  assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr))
    else $error("read and write strobes overlap");

  // R4: setup clock of chip select before a strobe
  assert_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd) || $rose(bus_wr)) |-> $past(bus_cs))
    else $error("strobe without setup clock");

  // R4: hold clock of chip select after a strobe
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rd) || $fell(bus_wr)) |-> bus_cs)
    else $error("strobe without hold clock");

  // R6: launch raises busy next clock without a strobe
  assert_launch_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy && (start_rd || start_wr)) |=> (busy && !bus_rd && !bus_wr))
    else $error("launch did not enter setup");

  // R1: disable stops the bus
  assert_disable_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bus_cs)
    else $error("bus active while disabled");
endmodule

// File: rtl/pmb_addr_drv.sv
module pmb_addr_drv #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] pins
);
  for (genvar i = 0; i < AW; i++) begin : g_pin
    assign pins[i] = mask[i] & addr[i];
  end
endmodule

// File: rtl/pmb_master.sv
module pmb_master
  import pmb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [1:0]    host_reg,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cs,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  output logic          irq
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          en, busy, cap_en, cyc_done, start_rd, start_wr;
  cfg_t          cfg;
  logic [AW-1:0] mask, addr;
  logic [DW-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pmb_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_reg(host_reg),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .cap_en(cap_en), .cap_data(bus_din), .cyc_done(cyc_done),
    .en(en), .cfg(cfg), .mask(mask), .addr(addr), .data(data),
    .start_rd(start_rd), .start_wr(start_wr)
  );

  pmb_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .en(en), .len(cfg.len),
    .start_rd(start_rd), .start_wr(start_wr),
    .busy(busy), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .cap_en(cap_en), .cyc_done(cyc_done)
  );

  pmb_addr_drv #(.AW(AW)) u_addr (
    .addr(addr), .mask(mask), .pins(bus_addr)
  );

  assign bus_dout = data;
  assign irq      = cyc_done & cfg.irq_en;

  // R9: interrupt sits in the hold clock and lasts one clock
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (bus_cs && !bus_rd && !bus_wr))
    else $error("interrupt outside hold clock");

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |=> (!irq && !bus_cs))
    else $error("interrupt longer than one clock");
endmodule

// File: tb/pmb_master_tb.sv
module pmb_master_tb;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_sel, host_wr;
  logic [1:0]    host_reg;
  logic [DW-1:0] host_wdata, host_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_cs, bus_rd, bus_wr, irq;
  logic [DW-1:0] bus_dout, bus_din;

  int errors = 0;
  int checks = 0;
  int irq_cnt = 0;

  always #4 clk = ~clk;

  pmb_master #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_reg(host_reg),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_dout(bus_dout), .bus_din(bus_din), .irq(irq)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  // len[52:49] word[48] addr[47:32] mask[31:16] din[15:0]
  localparam logic [52:0] VECS [0:5] = '{
    {4'd0,  1'b1, 16'h1234, 16'hFFFF, 16'hA5C3},
    {4'd3,  1'b0, 16'h00F0, 16'h00FF, 16'hBEEF},
    {4'd15, 1'b1, 16'hFFFF, 16'h0F0F, 16'h0001},
    {4'd7,  1'b1, 16'h8001, 16'hFF00, 16'hFFFF},
    {4'd1,  1'b0, 16'h5555, 16'hAAAA, 16'h1280},
    {4'd10, 1'b1, 16'h0000, 16'hFFFF, 16'h7E7E}
  };

  function automatic logic [15:0] ctrl_w(logic e, logic w, logic q, logic inc, logic [3:0] l);
    return {e, 8'h00, w, q, inc, l};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [1:0] r, logic [15:0] v);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_reg = r; host_wdata = v;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hread(logic [1:0] r, output logic [15:0] v);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_reg = r;
    #1 v = host_rdata;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  // called at the negedge right after launch (setup clock)
  task automatic watch(output int stb, output logic setup_ok, output logic hold_ok,
                       output logic irq_seen, output logic [15:0] a,
                       output logic saw_wr, output logic [15:0] dout);
    setup_ok = bus_cs && !bus_rd && !bus_wr;
    a = bus_addr;
    stb = 0; saw_wr = 1'b0; dout = '0;
    @(negedge clk);
    dout = bus_dout;
    while ((bus_rd || bus_wr) && stb < 40) begin
      stb++;
      if (bus_wr) saw_wr = 1'b1;
      @(negedge clk);
    end
    hold_ok = bus_cs && !bus_rd && !bus_wr;
    irq_seen = irq;
    @(negedge clk);
    hold_ok = hold_ok && !bus_cs;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 50 && bus_cs; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v, r1, r2, a, dout, expd;
    int stb;
    logic s_ok, h_ok, iq, swr;
    int irq0;

    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_reg = 2'd0;
    host_wdata = '0; bus_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state R2
    hread(2'd0, v); chk("R2 ctrl reset", v, 16'h0000);
    hread(2'd3, v); chk("R2 mask reset", v, 16'hFFFF);
    chk("R1 cs idle after reset", bus_cs, 1'b0);
    chk("R9 irq idle after reset", irq, 1'b0);

    // R1 disabled ignores accesses
    hwrite(2'd1, 16'h1234);
    hread(2'd1, v); chk("R1 addr write ignored", v, 16'h0000);
    hwrite(2'd2, 16'h5678);
    s_ok = 1'b1;
    for (int k = 0; k < 3; k++) begin @(negedge clk); if (bus_cs) s_ok = 1'b0; end
    chk("R1 no bus cycle while disabled", s_ok, 1'b1);
    hread(2'd2, v); chk("R1 data write ignored", v, 16'h0000);

    // Vector table: read cycles R3 R4 R8 R9 R11
    for (int i = 0; i < 6; i++) begin
      bus_din = VECS[i][15:0];
      hwrite(2'd0, ctrl_w(1'b0, VECS[i][48], 1'b1, 1'b0, VECS[i][52:49]));
      hwrite(2'd3, VECS[i][31:16]);
      hwrite(2'd0, ctrl_w(1'b1, VECS[i][48], 1'b1, 1'b0, VECS[i][52:49]));
      hwrite(2'd1, VECS[i][47:32]);
      hread(2'd2, v); chk("R3 dummy first read", v, 16'h0000);
      watch(stb, s_ok, h_ok, iq, a, swr, dout);
      chk("R4 strobe length", stb, 32'(VECS[i][52:49]) + 1);
      chk("R4 setup clock", s_ok, 1'b1);
      chk("R4 hold clock", h_ok, 1'b1);
      chk("R8 masked address", a, VECS[i][47:32] & VECS[i][31:16]);
      chk("R9 irq in hold", iq, 1'b1);
      expd = VECS[i][48] ? VECS[i][15:0] : {8'h00, VECS[i][7:0]};
      hread(2'd2, v); chk("R3 R11 prefetched data", v, expd);
      wait_idle();
      hwrite(2'd0, 16'h0000);
    end

    // R2 configuration lock
    hwrite(2'd3, 16'hFFFF);
    hwrite(2'd0, ctrl_w(1'b0, 1'b1, 1'b1, 1'b0, 4'd2));
    hwrite(2'd0, ctrl_w(1'b1, 1'b1, 1'b1, 1'b0, 4'd2));
    hwrite(2'd0, ctrl_w(1'b1, 1'b0, 1'b0, 1'b1, 4'd5));
    hread(2'd0, v); chk("R2 ctrl locked", v, ctrl_w(1'b1, 1'b1, 1'b1, 1'b0, 4'd2));
    hwrite(2'd3, 16'h00FF);
    hread(2'd3, v); chk("R2 mask locked", v, 16'hFFFF);

    // R5 write cycle
    hwrite(2'd1, 16'h0042);
    hwrite(2'd2, 16'hC0DE);
    watch(stb, s_ok, h_ok, iq, a, swr, dout);
    chk("R5 write strobe length", stb, 3);
    chk("R5 write strobe used", swr, 1'b1);
    chk("R5 write data out", dout, 16'hC0DE);
    chk("R5 write address", a, 16'h0042);
    chk("R5 hold clock", h_ok, 1'b1);

    // R7 back-to-back reads, R6 busy
    bus_din = 16'h3C3C;
    hread(2'd2, r1); chk("R3 returns held value", r1, 16'hC0DE);
    hread(2'd2, r2); chk("R7 busy read returns same value", r2, r1);
    hread(2'd0, v);
    chk("R6 busy during cycle", v[8], 1'b1);
    chk("R7 overflow set", v[9], 1'b1);
    wait_idle();
    s_ok = 1'b1;
    for (int k = 0; k < 3; k++) begin @(negedge clk); if (bus_cs) s_ok = 1'b0; end
    chk("R7 ignored read launched nothing", s_ok, 1'b1);
    hread(2'd2, v); chk("R4 captured bus data", v, 16'h3C3C);
    wait_idle();
    hread(2'd0, v);
    chk("R6 busy clear when idle", v[8], 1'b0);
    chk("R7 overflow sticky", v[9], 1'b1);
    hwrite(2'd0, 16'h0000);
    hread(2'd0, v); chk("R7 overflow cleared by disable", v[9], 1'b0);
    hread(2'd2, v); chk("R1 data cleared when disabled", v, 16'h0000);

    // R10 auto-increment, R9 irq disabled
    hwrite(2'd0, ctrl_w(1'b0, 1'b1, 1'b0, 1'b1, 4'd0));
    hwrite(2'd0, ctrl_w(1'b1, 1'b1, 1'b0, 1'b1, 4'd0));
    irq0 = irq_cnt;
    hwrite(2'd1, 16'h00FE);
    hread(2'd2, v);
    wait_idle();
    hread(2'd1, v); chk("R10 increment after read", v, 16'h00FF);
    hwrite(2'd2, 16'h1111);
    wait_idle();
    hread(2'd1, v); chk("R10 increment after write", v, 16'h0100);
    chk("R9 no irq when disabled", irq_cnt, irq0);
    hwrite(2'd0, 16'h0000);

    // R11 byte-mode write
    hwrite(2'd0, ctrl_w(1'b0, 1'b0, 1'b0, 1'b0, 4'd1));
    hwrite(2'd0, ctrl_w(1'b1, 1'b0, 1'b0, 1'b0, 4'd1));
    hwrite(2'd2, 16'hABCD);
    watch(stb, s_ok, h_ok, iq, a, swr, dout);
    chk("R11 byte write data", dout, 16'h00CD);
    chk("R4 two-clock strobe", stb, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule